// File: doc/BRIEF.md
# BF16 Pair Dot-Product Accumulator

This block computes, for every 32-bit lane of a vector, a single-precision result equal to an accumulator lane plus the dot product of two lanes that each pack two bfloat16 values. Each bfloat16 is widened to single precision by placing its 16 bits in the upper half of a 32-bit word. The two element-wise products are formed and rounded separately, added together with a rounding, and that sum is then added to the accumulator with a final rounding.

The arithmetic mode is fixed and ignores any control setting. It rounds to odd, overflows to infinity, flushes subnormal operands and subnormal results to signed zero, and replaces every NaN with the default quiet NaN. No exception flags are produced. One lane engine reuses a single single-precision multiply/add unit over four steps and talks to a lane walker through a valid/ready handshake. The walker processes lanes 0 up to the active count minus one and leaves every lane at or above that count at zero.

A run starts with a `start` pulse while the block is idle. The operand vectors must be held stable until `done`. The result vector stays unchanged until the next accepted start.

Top module: `bfdot_vec_engine`

## Requirements
- R1: Each result lane equals RO(acc + RO(RO(lo_n*lo_m) + RO(hi_n*hi_m))), where RO is the rounding of R2. The lo operand is source bits [15:0] placed in bits [31:16] of a single-precision word with zero below. The hi operand is source bits [31:16] placed the same way.
- R2: Every operation rounds to odd. The exact result is truncated to 23 fraction bits, and fraction bit 0 is forced to 1 when any discarded bit is nonzero (1.0 + 2^-24 gives 32'h3F800001).
- R3: A result whose exponent exceeds the largest finite value becomes a signed infinity (32'h7F800000 or 32'hFF800000).
- R4: An operand with exponent field 0 is used as zero of the same sign. A result whose unrounded magnitude is below 2^-126 is returned as zero of its sign, so no output lane ever has exponent field 0 with a nonzero fraction.
- R5: Every NaN result is 32'h7FC00000. This covers NaN operands, infinity times zero, and the sum of opposite infinities.
- R6: An exact zero sum of opposite-signed operands is +0 (32'h00000000). The sum of two zeros of the same sign keeps that sign.
- R7: Result lanes with index at or above the active count are 32'h00000000. An active count above LANES is treated as LANES. Lane i occupies bits [32*i+31:32*i] of each vector port.
- R8: `done` is a one-cycle pulse, 6*N+1 rising edges after the edge that accepts `start`, where N is the clamped active count. `busy` is high from the edge after that acceptance until `done` rises.
- R9: `start` is ignored while `busy` is high. `dst` keeps its value from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| act_lanes | input | $clog2(LANES+1) | Number of active lanes, sampled at start |
| src_n | input | 32*LANES | First bfloat16-pair vector |
| src_m | input | 32*LANES | Second bfloat16-pair vector |
| src_acc | input | 32*LANES | Single-precision accumulator vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| dst | output | 32*LANES | Result vector |

## Verification
Each lane is accepted one edge after the walker offers it. Its result is stored five edges after that acceptance, so lanes complete every six edges and `done` appears 6*N+1 edges after the start edge. The bench drives `start` on a falling edge, counts falling edges until `done` is seen high, and compares that count with 6*N+1. The result vector is read only in the cycle where `done` is seen and again a few cycles later, to confirm that it holds. Lane values are compared against fixed expected words for the corner cases and against a fixed-point reference model for random lanes.

// File: rtl/bfdot_pkg.sv
package bfdot_pkg;

    localparam logic [31:0] FP_QNAN = 32'h7FC0_0000;
    localparam int FRAC_W  = 23;
    localparam int GUARD_W = 26;
    localparam int ALN_W   = FRAC_W + 1 + GUARD_W;

    typedef enum logic [2:0] {
        PH_IDLE, PH_MUL_LO, PH_MUL_HI, PH_PAIR, PH_ACC, PH_DONE
    } lane_phase_e;

    typedef struct packed {
        lane_phase_e phase;
        logic [31:0] opn;
        logic [31:0] opm;
        logic [31:0] opa;
        logic [31:0] t_lo;
        logic [31:0] t_hi;
        logic [31:0] sum;
    } lane_state_t;

    function automatic logic [31:0] flush_in(input logic [31:0] x);
        return (x[30:23] == 8'd0) ? {x[31], 31'd0} : x;
    endfunction

    function automatic logic is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction

    function automatic logic is_inf(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] == 23'd0);
    endfunction

    function automatic logic is_zero(input logic [31:0] x);
        return x[30:0] == 31'd0;
    endfunction

    // Odd rounding never carries, so tiny/overflow tests on the unrounded exponent suffice.
    function automatic logic [31:0] pack_odd(input logic sgn, input int exp_b,
                                             input logic [22:0] frac, input logic lost);
        if (exp_b >= 255) return {sgn, 8'hFF, 23'd0};
        if (exp_b < 1) return {sgn, 31'd0};
        return {sgn, 8'(exp_b), frac | {22'd0, lost}};
    endfunction

    function automatic logic [31:0] fp_mul_odd(input logic [31:0] a_in, input logic [31:0] b_in);
        logic [31:0] a, b;
        logic        sgn;
        logic [47:0] prod;
        int          e;
        a   = flush_in(a_in);
        b   = flush_in(b_in);
        sgn = a[31] ^ b[31];
        if (is_nan(a) || is_nan(b)) return FP_QNAN;
        if (is_inf(a) || is_inf(b)) begin
            if (is_zero(a) || is_zero(b)) return FP_QNAN;
            return {sgn, 8'hFF, 23'd0};
        end
        if (is_zero(a) || is_zero(b)) return {sgn, 31'd0};
        prod = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
        e    = int'(a[30:23]) + int'(b[30:23]) - 127;
        if (prod[47]) return pack_odd(sgn, e + 1, prod[46:24], |prod[23:0]);
        return pack_odd(sgn, e, prod[45:23], |prod[22:0]);
    endfunction

    function automatic logic [31:0] fp_add_odd(input logic [31:0] a_in, input logic [31:0] b_in);
        logic [31:0]      a, b, big, sml;
        logic [ALN_W-1:0] mb, ms, msh;
        logic [ALN_W:0]   s, nrm;
        int               d, p, e;
        a = flush_in(a_in);
        b = flush_in(b_in);
        if (is_nan(a) || is_nan(b)) return FP_QNAN;
        if (is_inf(a) && is_inf(b)) return (a[31] != b[31]) ? FP_QNAN : a;
        if (is_inf(a)) return a;
        if (is_inf(b)) return b;
        if (is_zero(a) && is_zero(b)) return {a[31] & b[31], 31'd0};
        if (is_zero(a)) return b;
        if (is_zero(b)) return a;
        if (a[30:0] >= b[30:0]) begin
            big = a;
            sml = b;
        end else begin
            big = b;
            sml = a;
        end
        d  = int'(big[30:23]) - int'(sml[30:23]);
        mb = {1'b1, big[22:0], {GUARD_W{1'b0}}};
        ms = {1'b1, sml[22:0], {GUARD_W{1'b0}}};
        if (d >= ALN_W) begin
            msh = ALN_W'(1);
        end else begin
            msh = ms >> d;
            if ((msh << d) != ms) msh[0] = 1'b1;
        end
        if (big[31] == sml[31]) s = {1'b0, mb} + {1'b0, msh};
        else                    s = {1'b0, mb} - {1'b0, msh};
        if (s == '0) return 32'd0;
        p = 0;
        for (int i = 0; i <= ALN_W; i++) if (s[i]) p = i;
        nrm = s << (ALN_W - p);
        e   = int'(big[30:23]) + p - (ALN_W - 1);
        return pack_odd(big[31], e, nrm[ALN_W-1 -: FRAC_W], |nrm[ALN_W-FRAC_W-1:0]);
    endfunction

endpackage

// File: rtl/bfdot_fp_unit.sv
module bfdot_fp_unit
    import bfdot_pkg::*;
(
    input  logic        use_add,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic [31:0] result
);

    always_comb begin
        result = use_add ? fp_add_odd(src_a, src_b) : fp_mul_odd(src_a, src_b);
    end

endmodule

// File: rtl/bfdot_lane_engine.sv
module bfdot_lane_engine
    import bfdot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_n,
    input  logic [31:0] in_m,
    input  logic [31:0] in_acc,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data
);

    lane_state_t st_d, st_q;
    logic        u_add;
    logic [31:0] u_a, u_b, u_res;

    bfdot_fp_unit u_fp (
        .use_add (u_add),
        .src_a   (u_a),
        .src_b   (u_b),
        .result  (u_res)
    );

    // Operand steering for the shared unit, from registered state only.
    always_comb begin
        u_add = 1'b0;
        u_a   = 32'd0;
        u_b   = 32'd0;
        case (st_q.phase)
            PH_MUL_LO: begin
                u_a = {st_q.opn[15:0], 16'd0};
                u_b = {st_q.opm[15:0], 16'd0};
            end
            PH_MUL_HI: begin
                u_a = {st_q.opn[31:16], 16'd0};
                u_b = {st_q.opm[31:16], 16'd0};
            end
            PH_PAIR: begin
                u_add = 1'b1;
                u_a   = st_q.t_lo;
                u_b   = st_q.t_hi;
            end
            PH_ACC: begin
                u_add = 1'b1;
                u_a   = st_q.opa;
                u_b   = st_q.t_lo;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: if (in_valid) begin
                st_d.opn   = in_n;
                st_d.opm   = in_m;
                st_d.opa   = in_acc;
                st_d.phase = PH_MUL_LO;
            end
            PH_MUL_LO: begin
                st_d.t_lo  = u_res;
                st_d.phase = PH_MUL_HI;
            end
            PH_MUL_HI: begin
                st_d.t_hi  = u_res;
                st_d.phase = PH_PAIR;
            end
            PH_PAIR: begin
                st_d.t_lo  = u_res;
                st_d.phase = PH_ACC;
            end
            PH_ACC: begin
                st_d.sum   = u_res;
                st_d.phase = PH_DONE;
            end
            PH_DONE: if (out_ready) st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = (st_q.phase == PH_IDLE);
    assign out_valid = (st_q.phase == PH_DONE);
    assign out_data  = st_q.sum;

    assert_dnan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (u_res[30:23] == 8'hFF && u_res[22:0] != 23'd0) |-> (u_res == FP_QNAN));

    assert_no_subnormal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (u_res[30:23] == 8'd0) |-> (u_res[22:0] == 23'd0));

    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/bfdot_vec_engine.sv
module bfdot_vec_engine
    import bfdot_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(LANES+1)-1:0]    act_lanes,
    input  logic [32*LANES-1:0]           src_n,
    input  logic [32*LANES-1:0]           src_m,
    input  logic [32*LANES-1:0]           src_acc,
    output logic                          busy,
    output logic                          done,
    output logic [32*LANES-1:0]           dst
);

    localparam int CNT_W = $clog2(LANES + 1);
    localparam int VEC_W = 32 * LANES;

    typedef enum logic [1:0] {WK_IDLE, WK_ISSUE, WK_WAIT} walk_phase_e;

    typedef struct packed {
        walk_phase_e      phase;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [VEC_W-1:0] res;
    } walk_state_t;

    walk_state_t wk_d, wk_q;
    int          sel;
    logic        lane_in_valid, lane_in_ready;
    logic        lane_out_valid, lane_out_ready;
    logic [31:0] lane_out_data;

    always_comb begin
        sel = (int'(wk_q.idx) < LANES) ? int'(wk_q.idx) : 0;
    end

    assign lane_in_valid  = (wk_q.phase == WK_ISSUE) && (wk_q.idx != wk_q.cnt);
    assign lane_out_ready = (wk_q.phase == WK_WAIT);

    bfdot_lane_engine u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (lane_in_valid),
        .in_ready  (lane_in_ready),
        .in_n      (src_n[sel*32 +: 32]),
        .in_m      (src_m[sel*32 +: 32]),
        .in_acc    (src_acc[sel*32 +: 32]),
        .out_valid (lane_out_valid),
        .out_ready (lane_out_ready),
        .out_data  (lane_out_data)
    );

    always_comb begin
        wk_d      = wk_q;
        wk_d.done = 1'b0;
        case (wk_q.phase)
            WK_IDLE: if (start) begin
                wk_d.cnt   = (int'(act_lanes) > LANES) ? CNT_W'(LANES) : act_lanes;
                wk_d.idx   = '0;
                wk_d.res   = '0;
                wk_d.phase = WK_ISSUE;
            end
            WK_ISSUE: begin
                if (wk_q.idx == wk_q.cnt) begin
                    wk_d.done  = 1'b1;
                    wk_d.phase = WK_IDLE;
                end else if (lane_in_ready) begin
                    wk_d.phase = WK_WAIT;
                end
            end
            WK_WAIT: if (lane_out_valid) begin
                wk_d.res[sel*32 +: 32] = lane_out_data;
                wk_d.idx               = wk_q.idx + CNT_W'(1);
                wk_d.phase             = WK_ISSUE;
            end
            default: wk_d.phase = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign busy = (wk_q.phase != WK_IDLE);
    assign done = wk_q.done;
    assign dst  = wk_q.res;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    for (genvar g = 0; g < LANES; g++) begin : g_tail
        assert_tail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (done && int'(wk_q.cnt) <= g) |-> (dst[g*32 +: 32] == 32'd0));
    end

endmodule

// File: tb/bfdot_vec_engine_tb_top.sv
module bfdot_vec_engine_tb_top;

    localparam int LANES = 4;
    localparam int VW    = 32 * LANES;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    act_lanes = 3'd0;
    logic [VW-1:0] src_n = '0, src_m = '0, src_acc = '0;
    logic          busy, done;
    logic [VW-1:0] dst;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bfdot_vec_engine #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .act_lanes(act_lanes),
        .src_n(src_n), .src_m(src_m), .src_acc(src_acc),
        .busy(busy), .done(done), .dst(dst)
    );

    // Columns: n, m, acc, expected result.
    localparam logic [31:0] VEC_TBL [12][4] = '{
        '{32'h3F80_3F80, 32'h4000_4000, 32'h3F80_0000, 32'h40A0_0000}, // R1 2+2+1
        '{32'h4040_3F80, 32'h3F80_BF80, 32'h0000_0000, 32'h4000_0000}, // R1 3-1
        '{32'h7F00_0000, 32'h7F00_0000, 32'h0000_0000, 32'h7F80_0000}, // R3 product overflow
        '{32'h7F80_0000, 32'h0000_3F80, 32'h0000_0000, 32'h7FC0_0000}, // R5 inf*0
        '{32'h3F80_3F80, 32'hBF80_3F80, 32'h8000_0000, 32'h0000_0000}, // R6 cancel to +0
        '{32'h8000_8000, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000}, // R6 -0 kept
        '{32'h3380_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0001}, // R2 sticky to lsb
        '{32'h3F80_0000, 32'h3F80_0000, 32'h0040_0000, 32'h3F80_0000}, // R4 input flush
        '{32'h1F80_0000, 32'h2000_0000, 32'h0000_0000, 32'h0000_0000}, // R4 output flush
        '{32'h0000_0000, 32'h0000_0000, 32'h7F80_0001, 32'h7FC0_0000}, // R5 NaN operand
        '{32'h7F80_FF80, 32'h3F80_3F80, 32'h0000_0000, 32'h7FC0_0000}, // R5 inf-inf
        '{32'hFF7F_0000, 32'h3F80_0000, 32'hFF7F_FFFF, 32'hFF80_0000}  // R3 negative overflow
    };
    string tbl_req [12] = '{"R1", "R1", "R3", "R5", "R6", "R6", "R2", "R4", "R4", "R5", "R5", "R3"};

    // ---------------- reference model: exact fixed point ----------------
    function automatic logic [31:0] m_flush(input logic [31:0] x);
        return (x[30:23] == 8'd0) ? {x[31], 31'd0} : x;
    endfunction

    function automatic logic [31:0] m_round(input logic sgn, input logic [299:0] mag, input int lsb);
        int            p, be;
        logic [299:0]  low;
        logic [22:0]   fr;
        p = -1;
        for (int i = 0; i < 300; i++) if (mag[i]) p = i;
        be = p + lsb + 127;
        if (be > 254) return {sgn, 8'hFF, 23'd0};
        if (be < 1)   return {sgn, 31'd0};
        fr  = 23'(mag >> (p - 23));
        low = mag << (300 - (p - 23));
        return {sgn, 8'(be), fr | {22'd0, low != '0}};
    endfunction

    function automatic logic [31:0] m_mul(input logic [31:0] x, input logic [31:0] y);
        logic [31:0] a, b;
        logic [47:0] pr;
        logic        s;
        a = m_flush(x); b = m_flush(y); s = a[31] ^ b[31];
        if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return 32'h7FC0_0000;
        if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) begin
            if (a[30:0] == 0 || b[30:0] == 0) return 32'h7FC0_0000;
            return {s, 8'hFF, 23'd0};
        end
        if (a[30:0] == 0 || b[30:0] == 0) return {s, 31'd0};
        pr = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
        return m_round(s, 300'(pr), int'(a[30:23]) + int'(b[30:23]) - 300);
    endfunction

    function automatic logic [31:0] m_add(input logic [31:0] x, input logic [31:0] y);
        logic [31:0]  a, b;
        logic [299:0] ma, mb;
        a = m_flush(x); b = m_flush(y);
        if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return 32'h7FC0_0000;
        if (a[30:23] == 8'hFF && b[30:23] == 8'hFF) return (a[31] == b[31]) ? a : 32'h7FC0_0000;
        if (a[30:23] == 8'hFF) return a;
        if (b[30:23] == 8'hFF) return b;
        ma = (a[30:0] == 0) ? '0 : (300'({1'b1, a[22:0]}) << (int'(a[30:23]) - 1));
        mb = (b[30:0] == 0) ? '0 : (300'({1'b1, b[22:0]}) << (int'(b[30:23]) - 1));
        if (ma == 0 && mb == 0) return {a[31] & b[31], 31'd0};
        if (a[31] == b[31]) return m_round(a[31], ma + mb, -149);
        if (ma > mb) return m_round(a[31], ma - mb, -149);
        if (mb > ma) return m_round(b[31], mb - ma, -149);
        return 32'd0;
    endfunction

    function automatic logic [31:0] m_dot(input logic [31:0] n, input logic [31:0] m, input logic [31:0] a);
        logic [31:0] plo, phi;
        plo = m_mul({n[15:0], 16'd0}, {m[15:0], 16'd0});
        phi = m_mul({n[31:16], 16'd0}, {m[31:16], 16'd0});
        return m_add(a, m_add(plo, phi));
    endfunction

    function automatic logic [31:0] tame32(input bit bf);
        logic [31:0] w;
        w = $urandom;
        w[30:23] = 8'(120 + ($urandom % 16));
        if (bf) w[15:0] = 16'd0;
        return w;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, got, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic run_vec(input logic [VW-1:0] n, input logic [VW-1:0] m, input logic [VW-1:0] a,
                           input logic [2:0] act, input bit poke,
                           output logic [VW-1:0] res, output int cyc);
        @(negedge clk);
        src_n = n; src_m = m; src_acc = a; act_lanes = act; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                start = 1'b1; act_lanes = 3'd4;
            end else if (poke && cyc == 3) begin
                start = 1'b0; act_lanes = act;
            end
        end
        res = dst;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] vn, vm, va, res, res2;
        int            cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: R8 busy/done low, R7 result vector zero.
        chk_int("R8", "reset busy", int'(busy), 0);
        chk_int("R8", "reset done", int'(done), 0);
        chk("R7", "reset dst lane0", dst[31:0], 32'd0);

        // Table walk: three full-width runs of four entries.
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < LANES; j++) begin
                vn[j*32 +: 32] = VEC_TBL[4*r+j][0];
                vm[j*32 +: 32] = VEC_TBL[4*r+j][1];
                va[j*32 +: 32] = VEC_TBL[4*r+j][2];
            end
            run_vec(vn, vm, va, 3'd4, 1'b0, res, cyc);
            chk_int("R8", "done latency 4 lanes", cyc, 25);
            for (int j = 0; j < LANES; j++)
                chk(tbl_req[4*r+j], $sformatf("table entry %0d", 4*r+j), res[j*32 +: 32], VEC_TBL[4*r+j][3]);
        end

        // R7 partial vector: lanes 2 and 3 zero.
        for (int j = 0; j < LANES; j++) begin
            vn[j*32 +: 32] = tame32(1'b0); vm[j*32 +: 32] = tame32(1'b0); va[j*32 +: 32] = tame32(1'b0);
        end
        run_vec(vn, vm, va, 3'd2, 1'b0, res, cyc);
        chk_int("R8", "done latency 2 lanes", cyc, 13);
        for (int j = 0; j < LANES; j++)
            chk(j < 2 ? "R1" : "R7", $sformatf("act2 lane %0d", j), res[j*32 +: 32],
                j < 2 ? m_dot(vn[j*32 +: 32], vm[j*32 +: 32], va[j*32 +: 32]) : 32'd0);

        // R7 zero active lanes.
        run_vec(vn, vm, va, 3'd0, 1'b0, res, cyc);
        chk_int("R8", "done latency 0 lanes", cyc, 1);
        chk("R7", "act0 all lanes zero", 32'(res != '0), 32'd0);

        // R7 clamp: count 7 treated as 4.
        run_vec(vn, vm, va, 3'd7, 1'b0, res, cyc);
        chk_int("R7", "clamped latency", cyc, 25);
        chk("R7", "clamped lane3", res[127:96], m_dot(vn[127:96], vm[127:96], va[127:96]));

        // R9 start ignored while busy; result held after done.
        run_vec(vn, vm, va, 3'd1, 1'b1, res, cyc);
        chk_int("R9", "latency with start while busy", cyc, 7);
        chk("R9", "lane1 untouched by ignored start", res[63:32], 32'd0);
        chk("R1", "lane0 after ignored start", res[31:0], m_dot(vn[31:0], vm[31:0], va[31:0]));
        src_n = ~src_n;
        repeat (5) @(negedge clk);
        res2 = dst;
        chk("R9", "dst held after done", 32'(res2 != res), 32'd0);
        chk_int("R9", "idle after done", int'(busy), 0);

        // Random lanes against the model (R1-family values, R2..R6 as they arise).
        for (int t = 0; t < 40; t++) begin
            for (int j = 0; j < LANES; j++) begin
                if (t < 20) begin
                    vn[j*32 +: 32] = {tame32(1'b1)[31:16], tame32(1'b1)[31:16]};
                    vm[j*32 +: 32] = {tame32(1'b1)[31:16], tame32(1'b1)[31:16]};
                    va[j*32 +: 32] = tame32(1'b0);
                end else begin
                    vn[j*32 +: 32] = $urandom; vm[j*32 +: 32] = $urandom; va[j*32 +: 32] = $urandom;
                end
            end
            run_vec(vn, vm, va, 3'd4, 1'b0, res, cyc);
            for (int j = 0; j < LANES; j++)
                chk("R1", $sformatf("random run %0d lane %0d", t, j), res[j*32 +: 32],
                    m_dot(vn[j*32 +: 32], vm[j*32 +: 32], va[j*32 +: 32]));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule